// File: doc/BRIEF.md
# Push Buffer Command Stream Decoder

The decoder sits between a command-list word stream and the register write ports of a graphics front end. Each 32-bit word it accepts is either a command header or an argument that belongs to the most recent header. A header names a method address, a subchannel, a word count and an addressing mode. The decoder turns that header and its arguments into a series of single register writes, each made of subchannel, method and data.

Writes whose method address is below 0x100 go to the puller port, which handles housekeeping in the stream front end. All other writes leave on the engine port, tagged with the engine identifier that was last bound to the header's subchannel. A write to method 0 binds its data to the subchannel. The decoder holds one binding for each of the eight subchannels. Output writes are combinational from the accepted word, so each argument costs one cycle when the target port is ready.

Top module: `pb_decoder`

## Requirements
- R1: A header carries its method in bits 12-0, its subchannel in bits 15-13, its word count in bits 27-16 and its mode in bits 31-29. In counted modes, bit 28 is not part of the count. The argument words for a header follow that header directly in the stream.
- R2: Modes 1 and 0 are incrementing. Argument i of a header is written to method+i, and the method address wraps modulo 2^13.
- R3: Modes 3 and 2 are fixed. Every argument of a header is written to the header's method.
- R4: Mode 4 is inline. The header takes no argument words and produces one write to its method. The data of that write is bits 28-16 of the header, zero-extended.
- R5: Mode 5 advances once. The first argument is written to the method and every later argument is written to method+1.
- R6: A write with a method below 0x100 appears only on the puller port. Any other write appears only on the engine port, together with its subchannel and the engine identifier bound to that subchannel.
- R7: An accepted write to method 0 stores the low ENG_W bits of its data as the engine identifier of its subchannel. The new binding applies from the next word onward. The write itself is still sent on the puller port.
- R8: A header in mode 6 or 7 is consumed with no write. err is high for that cycle, and the next word is decoded as a header.
- R9: A header with count 0 in any non-inline mode produces no write, and the next word is decoded as a header.
- R10: While a pending write's target port has ready low, in_ready is low and no word is lost or repeated. Headers that produce no write are accepted whatever the state of the output ready signals.
- R11: After reset the decoder expects a header, no write is pending, and every subchannel is bound to engine identifier 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Command word valid |
| in_data | input | 32 | Command word |
| in_ready | output | 1 | Command word accepted when high together with in_valid |
| pl_valid | output | 1 | Puller write valid |
| pl_ready | input | 1 | Puller write accepted |
| pl_method | output | 13 | Puller method address |
| pl_data | output | 32 | Puller write data |
| en_valid | output | 1 | Engine write valid |
| en_ready | input | 1 | Engine write accepted |
| en_subch | output | 3 | Subchannel of the engine write |
| en_method | output | 13 | Engine method address |
| en_data | output | 32 | Engine write data |
| en_engine | output | ENG_W | Engine identifier bound to en_subch |
| err | output | 1 | Pulse when a header with an illegal mode is consumed |

## Verification
Two functions can fall in the same cycle. The first is back-pressure on a write. The second is the step from the final argument of one header to decoding the next header, and a related case is a bind followed at once by an engine write on the same subchannel. The bench provokes both by running the same command program twice: once with every ready held high, and once with pseudo-random ready and valid gaps. The second pass therefore stalls final arguments, inline headers and bind writes at varied points. A behavioural model expands the program into an ordered list of expected writes and error pulses. Every cycle, whatever the outputs show is compared against the head of that list, and a stalled write must also hold in_ready low.

// File: rtl/pb_decoder.sv
module pb_decoder #(
  parameter int ENG_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [31:0]      in_data,
  output logic             in_ready,
  output logic             pl_valid,
  input  logic             pl_ready,
  output logic [12:0]      pl_method,
  output logic [31:0]      pl_data,
  output logic             en_valid,
  input  logic             en_ready,
  output logic [2:0]       en_subch,
  output logic [12:0]      en_method,
  output logic [31:0]      en_data,
  output logic [ENG_W-1:0] en_engine,
  output logic             err
);
  localparam int NSUB = 8;
  localparam logic [1:0] K_INC = 2'd0, K_FIX = 2'd1, K_ONE = 2'd2;

  logic              in_arg;
  logic [11:0]       left;
  logic [12:0]       mth;
  logic [2:0]        sub;
  logic [1:0]        kind;
  logic [ENG_W-1:0]  bind_q [NSUB];

  wire [2:0]  h_mode   = in_data[31:29];
  wire [11:0] h_cnt    = in_data[27:16];
  wire        h_inline = !in_arg && (h_mode == 3'd4);
  wire        h_bad    = !in_arg && (h_mode[2:1] == 2'b11);
  wire        do_wr    = in_valid && (in_arg || h_inline);

  wire [12:0] w_method = in_arg ? mth : in_data[12:0];
  wire [2:0]  w_sub    = in_arg ? sub : in_data[15:13];
  wire [31:0] w_data   = in_arg ? in_data : {19'd0, in_data[28:16]};
  wire        to_pl    = (w_method < 13'h100);

  assign pl_valid  = do_wr && to_pl;
  assign en_valid  = do_wr && !to_pl;
  assign pl_method = w_method;
  assign pl_data   = w_data;
  assign en_method = w_method;
  assign en_data   = w_data;
  assign en_subch  = w_sub;
  assign en_engine = bind_q[w_sub];
  assign in_ready  = !(in_arg || h_inline) || (to_pl ? pl_ready : en_ready);

  wire acc = in_valid && in_ready;
  assign err = acc && h_bad;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_arg <= 1'b0;
      left   <= '0;
      mth    <= '0;
      sub    <= '0;
      kind   <= K_INC;
      for (int i = 0; i < NSUB; i++) bind_q[i] <= '0;
    end else if (acc) begin
      if (!in_arg) begin
        if (!h_inline && !h_bad && h_cnt != 12'd0) begin
          in_arg <= 1'b1;
          left   <= h_cnt;
          mth    <= in_data[12:0];
          sub    <= in_data[15:13];
          kind   <= (h_mode == 3'd5) ? K_ONE : (h_mode[1] ? K_FIX : K_INC);
        end
      end else begin
        left <= left - 12'd1;
        if (left == 12'd1) in_arg <= 1'b0;
        case (kind)
          K_INC:   mth <= mth + 13'd1;
          K_ONE: begin
            mth  <= mth + 13'd1;
            kind <= K_FIX;
          end
          default: ;
        endcase
      end
      if (do_wr && w_method == 13'd0) bind_q[w_sub] <= w_data[ENG_W-1:0];
    end
  end

  assert_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready) |=> ($stable(left) && $stable(mth) && $stable(in_arg)));

  assert_last_arg_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_arg && left == 12'd1) |=> !in_arg);

  assert_incr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_arg && kind == K_INC) |=> (mth == $past(mth) + 13'd1));

  assert_once_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_arg && kind == K_ONE) |=> (mth == $past(mth) + 13'd1 && kind == K_FIX));

  assert_bind_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && do_wr && w_method == 13'd0) |=> (bind_q[$past(w_sub)] == $past(w_data[ENG_W-1:0])));

  assert_bad_mode_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!pl_valid && !en_valid) ##1 !in_arg);
endmodule

// File: tb/pb_decoder_tb.sv
module pb_decoder_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [31:0] in_data = '0;
  logic in_ready;
  logic pl_valid, en_valid, err;
  logic pl_ready = 1'b1, en_ready = 1'b1;
  logic [12:0] pl_method, en_method;
  logic [31:0] pl_data, en_data;
  logic [2:0] en_subch;
  logic [15:0] en_engine;

  pb_decoder #(.ENG_W(16)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .pl_valid(pl_valid), .pl_ready(pl_ready), .pl_method(pl_method), .pl_data(pl_data),
    .en_valid(en_valid), .en_ready(en_ready), .en_subch(en_subch), .en_method(en_method),
    .en_data(en_data), .en_engine(en_engine), .err(err)
  );

  always #4 clk = ~clk;

  typedef struct packed {
    logic [1:0]  typ;
    logic [2:0]  sub;
    logic [12:0] mth;
    logic [31:0] data;
    logic [15:0] eng;
  } ev_t;

  ev_t   eq[$];
  string rq[$];
  logic [31:0] wq[$];
  string cur_req = "R1";

  int errors = 0;
  int checks = 0;

  bit          m_arg = 0;
  int          m_left = 0;
  logic [12:0] m_mth = '0;
  logic [2:0]  m_sub = '0;
  int          m_kind = 0;
  logic [15:0] m_bind [8] = '{default: 16'h0};

  function automatic logic [31:0] hdr(input int mode, input int sub, input int mth, input int fld);
    return {mode[2:0], fld[12:0], sub[2:0], mth[12:0]};
  endfunction

  task automatic emit(input logic [2:0] s, input logic [12:0] m, input logic [31:0] d);
    ev_t e;
    e.sub = s; e.mth = m; e.data = d; e.eng = m_bind[s];
    e.typ = (m < 13'h100) ? 2'd0 : 2'd1;
    eq.push_back(e); rq.push_back(cur_req);
    if (m == 13'd0) m_bind[s] = d[15:0];
  endtask

  task automatic put(input logic [31:0] w);
    ev_t e;
    wq.push_back(w);
    if (!m_arg) begin
      if (w[31:29] >= 3'd6) begin
        e = '0; e.typ = 2'd2;
        eq.push_back(e); rq.push_back(cur_req);
      end else if (w[31:29] == 3'd4) begin
        emit(w[15:13], w[12:0], {19'd0, w[28:16]});
      end else if (w[27:16] != 12'd0) begin
        m_arg = 1; m_left = int'(w[27:16]); m_mth = w[12:0]; m_sub = w[15:13];
        m_kind = (w[31:29] == 3'd5) ? 2 : (w[30] ? 1 : 0);
      end
    end else begin
      emit(m_sub, m_mth, w);
      m_left--;
      if (m_left == 0) m_arg = 0;
      if (m_kind == 0) m_mth = m_mth + 13'd1;
      else if (m_kind == 2) begin m_mth = m_mth + 13'd1; m_kind = 1; end
    end
  endtask

  task automatic build();
    cur_req = "R7"; put(hdr(1, 2, 0, 1)); put(32'h0000_B197);
    cur_req = "R4"; put(hdr(4, 5, 0, 13'h0A14));
    cur_req = "R2"; put(hdr(1, 2, 13'h200, 3)); put(32'h1111_0001); put(32'h2222_0002); put(32'h3333_0003);
    cur_req = "R2"; put(hdr(0, 5, 13'h1FFE, 3)); put(32'hA000_000A); put(32'hB000_000B); put(32'h0000_CAFE);
    cur_req = "R3"; put(hdr(3, 0, 13'h040, 2)); put(32'h0000_0040); put(32'h0000_0041);
    cur_req = "R3"; put(hdr(2, 2, 13'h300, 2)); put(32'hDEAD_BEEF); put(32'h0BAD_F00D);
    cur_req = "R5"; put(hdr(5, 2, 13'hE00, 4)); put(32'h5); put(32'h6); put(32'h7); put(32'h8);
    cur_req = "R5"; put(hdr(5, 3, 13'h100, 1)); put(32'h0000_0099);
    cur_req = "R9"; put(hdr(1, 2, 13'h222, 0)); put(hdr(3, 2, 13'h223, 0));
    cur_req = "R4"; put(hdr(4, 2, 13'h333, 5));
    cur_req = "R8"; put(hdr(6, 1, 13'h444, 3)); put(hdr(7, 1, 13'h555, 0));
    cur_req = "R6"; put(hdr(4, 1, 13'h0FF, 13'h1FFF)); put(hdr(4, 3, 13'h100, 1));
    cur_req = "R7"; put(hdr(3, 2, 0, 1)); put(32'h0000_1234); put(hdr(4, 2, 13'h500, 7));
    cur_req = "R11"; put(hdr(4, 7, 13'h600, 9));
    cur_req = "R1"; put(hdr(1, 4, 13'h700, 13'h1002)); put(32'h77); put(32'h78);
  endtask

  task automatic fail_line(input string req, input ev_t got, input ev_t exp);
    errors++;
    $display("FAIL %s: got typ=%0d sub=%0d m=%h d=%h e=%h, expected typ=%0d sub=%0d m=%h d=%h e=%h",
             req, got.typ, got.sub, got.mth, got.data, got.eng,
             exp.typ, exp.sub, exp.mth, exp.data, exp.eng);
  endtask

  task automatic check_cycle();
    ev_t g, e;
    bit ok;
    if (pl_valid && en_valid) begin
      checks++; errors++;
      $display("FAIL R6: both ports valid, got pl=1 en=1, expected one");
    end
    if (err || pl_valid || en_valid) begin
      g = '0;
      g.typ = err ? 2'd2 : (pl_valid ? 2'd0 : 2'd1);
      if (pl_valid) begin g.mth = pl_method; g.data = pl_data; end
      if (en_valid) begin g.mth = en_method; g.data = en_data; g.sub = en_subch; g.eng = en_engine; end
      checks++;
      if (eq.size() == 0) begin
        fail_line("R1", g, '0);
      end else begin
        e = eq[0];
        ok = (g.typ == e.typ);
        if (ok && e.typ != 2'd2) ok = (g.mth == e.mth) && (g.data == e.data);
        if (ok && e.typ == 2'd1) ok = (g.sub == e.sub) && (g.eng == e.eng);
        if (!ok) fail_line(rq[0], g, e);
        if (err || (pl_valid && pl_ready) || (en_valid && en_ready)) begin
          void'(eq.pop_front()); void'(rq.pop_front());
        end
      end
    end
    if ((pl_valid && !pl_ready) || (en_valid && !en_ready)) begin
      checks++;
      if (in_ready !== 1'b0) begin
        errors++;
        $display("FAIL R10: in_ready during stall got %b expected 0", in_ready);
      end
    end
  endtask

  initial begin
    logic [15:0] lfsr = 16'hACE1;
    int widx = 0;
    int cyc = 0;
    int half;
    bit stress, hold;
    build();
    half = wq.size();
    build();

    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    checks++;
    if (pl_valid !== 1'b0 || en_valid !== 1'b0 || err !== 1'b0 || in_ready !== 1'b1) begin
      errors++;
      $display("FAIL R11: reset outputs got pl=%b en=%b err=%b rdy=%b expected 0 0 0 1",
               pl_valid, en_valid, err, in_ready);
    end
    rst_n = 1'b1;

    hold = 0;
    while (widx < wq.size() && cyc < 20000) begin
      @(negedge clk);
      cyc++;
      stress = (widx >= half);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      in_valid = hold || !stress || lfsr[0] || lfsr[3];
      in_data  = wq[widx];
      pl_ready = !stress || lfsr[1];
      en_ready = !stress || lfsr[2] || lfsr[5];
      #1;
      check_cycle();
      hold = in_valid && !in_ready;
      if (in_valid && in_ready) widx++;
    end
    if (cyc >= 20000) begin
      checks++; errors++;
      $display("FAIL R10: watchdog got %0d words expected %0d", widx, wq.size());
    end

    @(negedge clk);
    in_valid = 1'b0; pl_ready = 1'b1; en_ready = 1'b1;
    for (int i = 0; i < 5; i++) begin
      #1; check_cycle();
      @(negedge clk);
    end
    checks++;
    if (eq.size() != 0) begin
      errors++;
      $display("FAIL %s: missing writes got %0d left expected 0", rq[0], eq.size());
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule